// File: doc/BRIEF.md
# CAN Configuration Register Write Lock

This block is the register front end of a CAN controller. Software reaches it over a plain synchronous register bus that carries an address, write data, a write strobe and read data. The block stores the mode control bits, the protocol configuration registers (module control, bit timing, acceptance filter control, acceptance identifiers and acceptance masks), and gives read-only views of the transmit and receive error counters. The protocol engine, which lives elsewhere, supplies those counters.

A soft-reset bit guards the protocol configuration. While that bit is set the controller is off-line and every configuration register takes writes. Once software clears the bit to bring the controller on-line, writes to those registers are dropped without any error indication, so a stray store cannot change timing or filtering under live traffic. The error counters cannot be written in any mode. The transmit line is held recessive while any low-power mode is selected.

The register bus has no back-pressure. Every write is taken in the cycle its strobe is high, and read data is a combinational function of the address and the current register contents. No handshake is needed and there are no wait states.

Top module: `can_cfg_lock`

## Requirements
- R1: After reset, the mode register reads 0x01 (soft reset set, sleep and power-down clear), and every protocol configuration register reads 0x00.
- R2: The mode register at address 0x00 accepts writes in every mode. Bit 0 is soft reset, bit 1 is sleep and bit 2 is power-down. Upper bits read as zero, and the stored bits appear on the mode outputs on the next cycle.
- R3: While soft reset is set, a write to a protected register (0x01 module control, 0x02/0x03 bit timing, 0x04 filter control, 0x08–0x0B acceptance identifiers 0–3, 0x0C–0x0F acceptance masks 0–3) is stored. It is visible on reads and on its configuration output from the next cycle.
- R4: While soft reset is clear, a write to any protected register is dropped and its contents and configuration output stay unchanged.
- R5: A read of 0x10 returns the transmit error counter input and a read of 0x11 returns the receive error counter input, each as sampled at the previous clock edge.
- R6: Writes to 0x10 and 0x11 have no effect in any mode; reads keep following the counter inputs.
- R7: Unmapped addresses (0x05–0x07, 0x12 and above) read as zero, and writes to them change no register.
- R8: The CAN transmit output is 1 (recessive) whenever soft reset, sleep or power-down is set. Otherwise it follows the engine's transmit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_err_cnt | input | 8 | Transmit error counter from the engine |
| rx_err_cnt | input | 8 | Receive error counter from the engine |
| eng_tx_bit | input | 1 | Transmit bit from the engine |
| can_tx | output | 1 | Transmit line, forced recessive in low-power modes |
| soft_rst_o | output | 1 | Soft reset (off-line) mode |
| sleep_o | output | 1 | Sleep mode |
| pwrdn_o | output | 1 | Power-down mode |
| ctrl1_o | output | 8 | Module control register 1 |
| timing0_o | output | 8 | Bit timing register 0 |
| timing1_o | output | 8 | Bit timing register 1 |
| acc_ctrl_o | output | 8 | Acceptance filter control |
| acc_id_o | output | 32 | Acceptance identifiers 0–3, identifier 0 in bits 7:0 |
| acc_mask_o | output | 32 | Acceptance masks 0–3, mask 0 in bits 7:0 |

## Verification
The lock is exercised with three patterns. The first is a sweep of distinct writes to every protected register while off-line, which shows each address reaches its own register. The second repeats the sweep after going on-line, which separates a working lock from one that gates only some registers. The third is a long random mix of mode writes, protected writes, counter writes and unmapped accesses with changing counter inputs. That mix catches lock decisions taken from the wrong cycle and writes that leak through aliasing. Toggling the engine transmit bit under each mode combination shows whether each low-power bit on its own forces the line recessive.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
  localparam int unsigned MODE_ADDR = 0;
  localparam int unsigned CORE_FIRST = 1;   // module control 1, timing 0/1, filter control
  localparam int unsigned CORE_CNT = 4;
  localparam int unsigned FILT_BASE = 8;    // identifiers, then masks, contiguous

  function automatic int unsigned prot_addr(int unsigned idx);
    if (idx < CORE_CNT) return CORE_FIRST + idx;
    return FILT_BASE + idx - CORE_CNT;
  endfunction

  function automatic int unsigned err_base(int unsigned nfilt);
    return FILT_BASE + 2 * nfilt;
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec import can_cfg_pkg::*; #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_FILTER = 4,
  localparam int unsigned NPROT = CORE_CNT + 2 * N_FILTER
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPROT-1:0]  prot_sel,
  output logic              mode_sel,
  output logic              txerr_sel,
  output logic              rxerr_sel
);
  localparam int unsigned ERRB = err_base(N_FILTER);

  for (genvar i = 0; i < NPROT; i++) begin : g_sel
    assign prot_sel[i] = (addr == ADDR_W'(prot_addr(i)));
  end

  assign mode_sel  = (addr == ADDR_W'(MODE_ADDR));
  assign txerr_sel = (addr == ADDR_W'(ERRB));
  assign rxerr_sel = (addr == ADDR_W'(ERRB + 1));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NPROT = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NPROT-1:0]        sel,
  input  logic                    unlocked,
  output logic [NPROT*DATA_W-1:0] regs_flat
);
  for (genvar i = 0; i < NPROT; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we && sel[i] && unlocked) q <= wdata;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/err_cnt_snap.sv
module err_cnt_snap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_in,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] rx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_in;
      rx_q <= rx_in;
    end
  end
endmodule

// File: rtl/can_cfg_lock.sv
module can_cfg_lock import can_cfg_pkg::*; #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_FILTER = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [DATA_W-1:0]          tx_err_cnt,
  input  logic [DATA_W-1:0]          rx_err_cnt,
  input  logic                       eng_tx_bit,
  output logic                       can_tx,
  output logic                       soft_rst_o,
  output logic                       sleep_o,
  output logic                       pwrdn_o,
  output logic [DATA_W-1:0]          ctrl1_o,
  output logic [DATA_W-1:0]          timing0_o,
  output logic [DATA_W-1:0]          timing1_o,
  output logic [DATA_W-1:0]          acc_ctrl_o,
  output logic [N_FILTER*DATA_W-1:0] acc_id_o,
  output logic [N_FILTER*DATA_W-1:0] acc_mask_o
);
  localparam int unsigned NPROT = CORE_CNT + 2 * N_FILTER;
  localparam int unsigned MODE_W = 3;

  logic [NPROT-1:0]        prot_sel;
  logic                    mode_sel, txerr_sel, rxerr_sel;
  logic [NPROT*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]       tx_q, rx_q;
  logic [MODE_W-1:0]       mode_q;   // {power-down, sleep, soft reset}

  cfg_addr_dec #(.ADDR_W(ADDR_W), .N_FILTER(N_FILTER)) u_dec (
    .addr(bus_addr), .prot_sel(prot_sel), .mode_sel(mode_sel),
    .txerr_sel(txerr_sel), .rxerr_sel(rxerr_sel)
  );

  cfg_reg_bank #(.DATA_W(DATA_W), .NPROT(NPROT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .wdata(bus_wdata),
    .sel(prot_sel), .unlocked(mode_q[0]), .regs_flat(regs_flat)
  );

  err_cnt_snap #(.DATA_W(DATA_W)) u_err (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_err_cnt), .rx_in(rx_err_cnt),
    .tx_q(tx_q), .rx_q(rx_q)
  );

  // Mode register: never locked, comes up off-line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_W'(1);
    else if (bus_we && mode_sel) mode_q <= bus_wdata[MODE_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (mode_sel) bus_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
    for (int i = 0; i < int'(NPROT); i++) begin
      if (prot_sel[i]) bus_rdata = regs_flat[i*DATA_W +: DATA_W];
    end
    if (txerr_sel) bus_rdata = tx_q;
    if (rxerr_sel) bus_rdata = rx_q;
  end

  assign soft_rst_o = mode_q[0];
  assign sleep_o    = mode_q[1];
  assign pwrdn_o    = mode_q[2];
  assign can_tx     = (|mode_q) ? 1'b1 : eng_tx_bit;

  assign ctrl1_o    = regs_flat[0*DATA_W +: DATA_W];
  assign timing0_o  = regs_flat[1*DATA_W +: DATA_W];
  assign timing1_o  = regs_flat[2*DATA_W +: DATA_W];
  assign acc_ctrl_o = regs_flat[3*DATA_W +: DATA_W];
  assign acc_id_o   = regs_flat[CORE_CNT*DATA_W +: N_FILTER*DATA_W];
  assign acc_mask_o = regs_flat[(CORE_CNT+N_FILTER)*DATA_W +: N_FILTER*DATA_W];
endmodule

// File: rtl/can_cfg_lock_chk.sv
module can_cfg_lock_chk import can_cfg_pkg::*; #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_FILTER = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [DATA_W-1:0]          tx_err_cnt,
  input logic                       can_tx,
  input logic                       soft_rst_o,
  input logic                       sleep_o,
  input logic                       pwrdn_o,
  input logic [DATA_W-1:0]          ctrl1_o,
  input logic [DATA_W-1:0]          timing0_o,
  input logic [DATA_W-1:0]          timing1_o,
  input logic [DATA_W-1:0]          acc_ctrl_o,
  input logic [N_FILTER*DATA_W-1:0] acc_id_o,
  input logic [N_FILTER*DATA_W-1:0] acc_mask_o
);
  localparam int unsigned ERRB = err_base(N_FILTER);
  logic [4*DATA_W+2*N_FILTER*DATA_W-1:0] cfg_all;
  logic unmapped;
  assign cfg_all = {ctrl1_o, timing0_o, timing1_o, acc_ctrl_o, acc_id_o, acc_mask_o};
  assign unmapped = (int'(bus_addr) > int'(CORE_CNT) && int'(bus_addr) < int'(FILT_BASE))
                 || int'(bus_addr) >= int'(ERRB + 2);

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(MODE_ADDR)) |=> (soft_rst_o == $past(bus_wdata[0]))); // R2
  AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && bus_we && bus_addr == ADDR_W'(CORE_FIRST)) |=> (ctrl1_o == $past(bus_wdata))); // R3
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(soft_rst_o)) |-> $stable(cfg_all)); // R4
  AST_ERR_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && bus_addr == ADDR_W'(ERRB)) |-> (bus_rdata == $past(tx_err_cnt))); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0)); // R7
  AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o || sleep_o || pwrdn_o) |-> can_tx); // R8
endmodule

bind can_cfg_lock can_cfg_lock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_FILTER(N_FILTER)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .tx_err_cnt(tx_err_cnt), .can_tx(can_tx), .soft_rst_o(soft_rst_o),
  .sleep_o(sleep_o), .pwrdn_o(pwrdn_o), .ctrl1_o(ctrl1_o), .timing0_o(timing0_o),
  .timing1_o(timing1_o), .acc_ctrl_o(acc_ctrl_o), .acc_id_o(acc_id_o), .acc_mask_o(acc_mask_o)
);

// File: tb/can_cfg_lock_test.sv
module can_cfg_lock_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        eng_tx_bit = 1'b0;
  logic        can_tx, soft_rst_o, sleep_o, pwrdn_o;
  logic [7:0]  ctrl1_o, timing0_o, timing1_o, acc_ctrl_o;
  logic [31:0] acc_id_o, acc_mask_o;

  can_cfg_lock uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .eng_tx_bit(eng_tx_bit), .can_tx(can_tx), .soft_rst_o(soft_rst_o), .sleep_o(sleep_o),
    .pwrdn_o(pwrdn_o), .ctrl1_o(ctrl1_o), .timing0_o(timing0_o), .timing1_o(timing1_o),
    .acc_ctrl_o(acc_ctrl_o), .acc_id_o(acc_id_o), .acc_mask_o(acc_mask_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Behavioural reference: a sparse register image plus the counter samples
  logic [7:0] m_reg [int];
  logic [2:0] m_mode;
  logic [7:0] m_tx, m_rx;

  function automatic bit is_prot(int a);
    return (a >= 1 && a <= 4) || (a >= 8 && a <= 15);
  endfunction

  function automatic logic [7:0] mreg(int a);
    return m_reg.exists(a) ? m_reg[a] : 8'h00;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int a = int'(bus_addr);
    logic [7:0] e;
    string tag;
    if (a == 0)               begin e = {5'b0, m_mode}; tag = "R2"; end
    else if (is_prot(a))      begin e = mreg(a); tag = m_mode[0] ? "R3" : "R4"; end
    else if (a == 16)         begin e = m_tx; tag = bus_we ? "R6" : "R5"; end
    else if (a == 17)         begin e = m_rx; tag = bus_we ? "R6" : "R5"; end
    else                      begin e = 8'h00; tag = "R7"; end
    check(bus_rdata == e, tag, "read data", 32'(bus_rdata), 32'(e));
    tag = m_mode[0] ? "R3" : "R4";
    check({ctrl1_o, timing0_o, timing1_o, acc_ctrl_o} == {mreg(1), mreg(2), mreg(3), mreg(4)},
          tag, "core config", {ctrl1_o, timing0_o, timing1_o, acc_ctrl_o},
          {mreg(1), mreg(2), mreg(3), mreg(4)});
    check(acc_id_o == {mreg(11), mreg(10), mreg(9), mreg(8)}, tag, "acceptance ids",
          acc_id_o, {mreg(11), mreg(10), mreg(9), mreg(8)});
    check(acc_mask_o == {mreg(15), mreg(14), mreg(13), mreg(12)}, tag, "acceptance masks",
          acc_mask_o, {mreg(15), mreg(14), mreg(13), mreg(12)});
    check({pwrdn_o, sleep_o, soft_rst_o} == m_mode, "R2", "mode outputs",
          32'({pwrdn_o, sleep_o, soft_rst_o}), 32'(m_mode));
    check(can_tx == ((m_mode != 0) ? 1'b1 : eng_tx_bit), "R8", "can_tx",
          32'(can_tx), 32'((m_mode != 0) ? 1'b1 : eng_tx_bit));
  endtask

  task automatic cyc(int a, bit w, logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_we = w; bus_wdata = d;
    eng_tx_bit = 1'($urandom); tx_err_cnt = 8'($urandom); rx_err_cnt = 8'($urandom);
    #1 compare_all();
    @(posedge clk);
    if (w) begin
      if (a == 0) m_mode = d[2:0];
      else if (is_prot(a) && m_mode[0]) m_reg[a] = d;
    end
    m_tx = tx_err_cnt; m_rx = rx_err_cnt;
  endtask

  initial begin
    m_mode = 3'b001; m_tx = '0; m_rx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(soft_rst_o == 1'b1 && sleep_o == 1'b0 && pwrdn_o == 1'b0, "R1", "mode after reset",
          32'({pwrdn_o, sleep_o, soft_rst_o}), 32'h1);
    check(bus_rdata == 8'h01, "R1", "mode read after reset", 32'(bus_rdata), 32'h01);
    check({ctrl1_o, timing0_o, timing1_o, acc_ctrl_o, acc_id_o, acc_mask_o} == '0, "R1",
          "config after reset", acc_id_o, 32'h0);
    // Off-line sweep: distinct value to every protected register
    for (int a = 0; a < 32; a++) if (is_prot(a)) cyc(a, 1'b1, 8'(8'hA0 + a));
    for (int a = 0; a < 32; a++) cyc(a, 1'b0, 8'h00);
    // Counter and unmapped writes while off-line
    cyc(16, 1'b1, 8'hFF); cyc(17, 1'b1, 8'hEE); cyc(5, 1'b1, 8'h55); cyc(20, 1'b1, 8'h77);
    for (int a = 0; a < 32; a++) cyc(a, 1'b0, 8'h00);
    // Go on-line and retry the sweep
    cyc(0, 1'b1, 8'h00);
    for (int a = 0; a < 32; a++) if (is_prot(a)) cyc(a, 1'b1, 8'(8'h3C ^ a));
    for (int a = 0; a < 32; a++) cyc(a, 1'b0, 8'h00);
    cyc(16, 1'b1, 8'h11); cyc(17, 1'b1, 8'h22);
    // Each low-power bit alone, engine bit toggling
    for (int m = 0; m < 8; m++) begin
      cyc(0, 1'b1, 8'(m | 8'hF8));
      for (int k = 0; k < 4; k++) cyc(16 + (k % 2), 1'b0, 8'h00);
    end
    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom_range(0, 9));
      int a = (r == 0) ? 0 : int'($urandom_range(0, 31));
      cyc(a, 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule